// File: doc/BRIEF.md
# Output Compare Channel with Forced Reference Levels

This block is a single output compare channel of a timer. Each clock it compares an external counter value with a compare value and updates an internal reference signal according to a three-bit mode code: hold, set on match, clear on match, toggle on match, forced inactive, forced active, or one of two pulse-width modes. The reference is always active-high. A separate polarity stage turns it into the pin level, and an output enable gates that level.

The channel acts as an output only while its two direction bits are 00. With any other direction code the reference holds its value and the pin is driven low. Both the reference and the pin are registered. A change on any input shows up on both outputs after one rising edge.

Top module: `occ_channel`

## Requirements
- R1: While `rst` is high at a rising edge, `oc_ref` and `oc_pin` are both 0 after that edge.
- R2: With mode 3'b101 (forced active) and direction 2'b00, `oc_ref` is 1 after the next edge, whatever the counter and compare values are.
- R3: With mode 3'b100 (forced inactive) and direction 2'b00, `oc_ref` is 0 after the next edge, even when the counter equals the compare value.
- R4: With mode 3'b000 (frozen), `oc_ref` keeps its value, even on a match.
- R5: With mode 3'b001, `oc_ref` becomes 1 on a cycle where the counter equals the compare value, and otherwise holds.
- R6: With mode 3'b010, `oc_ref` becomes 0 on a match, and otherwise holds.
- R7: With mode 3'b011, `oc_ref` inverts on every match cycle, and otherwise holds.
- R8: With mode 3'b110, `oc_ref` is 1 exactly when the counter is below the compare value (unsigned).
- R9: With mode 3'b111, `oc_ref` is 1 exactly when the counter is not below the compare value.
- R10: With `out_en`=1 and direction 2'b00, `oc_pin` equals the new `oc_ref` when `pol_inv`=0, and its inverse when `pol_inv`=1.
- R11: With `out_en`=0, `oc_pin` is 0 whatever `oc_ref` and `pol_inv` are.
- R12: With any direction code other than 2'b00, `oc_ref` holds its value regardless of mode, and `oc_pin` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current timer counter value |
| cmp_val | input | CNT_W | Compare value |
| oc_mode | input | 3 | Reference behaviour code |
| pol_inv | input | 1 | Pin polarity: 0 for active-high, 1 for active-low |
| out_en | input | 1 | Pin enable; the pin is 0 when this is low |
| dir_sel | input | 2 | Channel direction; 2'b00 selects output |
| oc_ref | output | 1 | Registered active-high reference |
| oc_pin | output | 1 | Registered pin level |

## Verification
The reference register is the only state, so a wrong value in it appears on `oc_ref` at the next edge. It stays visible under hold, frozen and non-output direction codes until a forced or pulse-width mode overwrites it. The set, clear and toggle tests first place the reference in a known state with a forced mode, so a stuck or inverted register shows up within one or two cycles. Because the pin register is loaded from the same next-state value as the reference, a polarity or enable fault appears in the same cycle as the reference change it follows.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN  = 3'b000,
    OCM_SET     = 3'b001,
    OCM_CLEAR   = 3'b010,
    OCM_TOGGLE  = 3'b011,
    OCM_FORCE_0 = 3'b100,
    OCM_FORCE_1 = 3'b101,
    OCM_PWM_LO  = 3'b110,
    OCM_PWM_HI  = 3'b111
  } ocm_e;

  localparam logic [1:0] DIR_OUTPUT = 2'b00;

endpackage

// File: rtl/occ_cmp.sv
module occ_cmp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit,
  output logic             below
);

  assign hit   = (cnt == cmp);
  assign below = (cnt <  cmp);

endmodule

// File: rtl/occ_refgen.sv
module occ_refgen
  import occ_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  ocm_e mode,
  input  logic hit,
  input  logic below,
  output logic ref_d,
  output logic ref_q
);

  always_comb begin
    ref_d = ref_q;
    if (active) begin
      case (mode)
        OCM_FROZEN:  ref_d = ref_q;
        OCM_SET:     ref_d = hit ? 1'b1 : ref_q;
        OCM_CLEAR:   ref_d = hit ? 1'b0 : ref_q;
        OCM_TOGGLE:  ref_d = hit ? ~ref_q : ref_q;
        OCM_FORCE_0: ref_d = 1'b0;
        OCM_FORCE_1: ref_d = 1'b1;
        OCM_PWM_LO:  ref_d = below;
        OCM_PWM_HI:  ref_d = ~below;
        default:     ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_d;
  end

  // R2
  force_act_chk: assert property (@(posedge clk) disable iff (rst)
    (active && mode == OCM_FORCE_1) |=> ref_q);

  // R3
  force_inact_chk: assert property (@(posedge clk) disable iff (rst)
    (active && mode == OCM_FORCE_0) |=> !ref_q);

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OCM_FROZEN) |=> $stable(ref_q));

  // R8
  pwm_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (active && mode == OCM_PWM_LO) |=> (ref_q == $past(below)));

  // R12
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(ref_q));

endmodule

// File: rtl/occ_polstage.sv
module occ_polstage (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ref_d,
  input  logic ref_q,
  input  logic pol,
  input  logic oe,
  output logic pin_q
);

  logic pin_d;

  assign pin_d = active & oe & (ref_d ^ pol);

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_d;
  end

  // R11
  oe_low_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |=> !pin_q);

  // R10
  pol_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && active) |=> (pin_q == (ref_q ^ $past(pol))));

  // R12
  dir_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pin_q);

endmodule

// File: rtl/occ_channel.sv
module occ_channel
  import occ_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       oc_mode,
  input  logic             pol_inv,
  input  logic             out_en,
  input  logic [1:0]       dir_sel,
  output logic             oc_ref,
  output logic             oc_pin
);

  logic hit, below, active, ref_d, ref_q;
  ocm_e mode;

  assign active = (dir_sel == DIR_OUTPUT);
  assign mode   = ocm_e'(oc_mode);

  occ_cmp #(.CNT_W(CNT_W)) u_cmp (
    .cnt   (cnt_val),
    .cmp   (cmp_val),
    .hit   (hit),
    .below (below)
  );

  occ_refgen u_ref (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .mode   (mode),
    .hit    (hit),
    .below  (below),
    .ref_d  (ref_d),
    .ref_q  (ref_q)
  );

  occ_polstage u_pol (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .ref_d  (ref_d),
    .ref_q  (ref_q),
    .pol    (pol_inv),
    .oe     (out_en),
    .pin_q  (oc_pin)
  );

  assign oc_ref = ref_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!oc_ref && !oc_pin));

endmodule

// File: tb/sim_occ_channel.sv
module sim_occ_channel;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cnt_val = '0;
  logic [CNT_W-1:0] cmp_val = '0;
  logic [2:0]       oc_mode = 3'b000;
  logic             pol_inv = 1'b0;
  logic             out_en  = 1'b1;
  logic [1:0]       dir_sel = 2'b00;
  logic             oc_ref, oc_pin;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  occ_channel #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cmp_val(cmp_val),
    .oc_mode(oc_mode), .pol_inv(pol_inv), .out_en(out_en),
    .dir_sel(dir_sel), .oc_ref(oc_ref), .oc_pin(oc_pin)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive inputs at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic [2:0] m, input int c, input int k);
    oc_mode = m;
    cnt_val = CNT_W'(c);
    cmp_val = CNT_W'(k);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    oc_mode = 3'b101;
    @(negedge clk);
    @(negedge clk);
    chk("R1 ref", oc_ref, 1'b0);
    chk("R1 pin", oc_pin, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_force;
    step(3'b101, 3, 9);   chk("R2 no match", oc_ref, 1'b1);
    step(3'b101, 9, 9);   chk("R2 match", oc_ref, 1'b1);
    step(3'b100, 9, 9);   chk("R3 match", oc_ref, 1'b0);
    step(3'b100, 1, 0);   chk("R3 above", oc_ref, 1'b0);
  endtask

  task automatic t_frozen;
    step(3'b101, 0, 1);
    step(3'b000, 5, 5);   chk("R4 hold 1", oc_ref, 1'b1);
    step(3'b000, 2, 7);   chk("R4 hold 1 again", oc_ref, 1'b1);
    step(3'b100, 0, 1);
    step(3'b000, 5, 5);   chk("R4 hold 0", oc_ref, 1'b0);
  endtask

  task automatic t_set_clear;
    step(3'b100, 0, 0);
    step(3'b001, 4, 6);   chk("R5 no match", oc_ref, 1'b0);
    step(3'b001, 6, 6);   chk("R5 match", oc_ref, 1'b1);
    step(3'b001, 7, 6);   chk("R5 held", oc_ref, 1'b1);
    step(3'b010, 8, 6);   chk("R6 no match", oc_ref, 1'b1);
    step(3'b010, 6, 6);   chk("R6 match", oc_ref, 1'b0);
    step(3'b010, 2, 6);   chk("R6 held", oc_ref, 1'b0);
  endtask

  task automatic t_toggle;
    step(3'b100, 0, 0);
    step(3'b011, 12, 12); chk("R7 first", oc_ref, 1'b1);
    step(3'b011, 12, 12); chk("R7 second", oc_ref, 1'b0);
    step(3'b011, 13, 12); chk("R7 no match", oc_ref, 1'b0);
    step(3'b011, 12, 12); chk("R7 third", oc_ref, 1'b1);
  endtask

  task automatic t_pwm;
    step(3'b110, 3, 5);   chk("R8 below", oc_ref, 1'b1);
    step(3'b110, 5, 5);   chk("R8 equal", oc_ref, 1'b0);
    step(3'b110, 7, 5);   chk("R8 above", oc_ref, 1'b0);
    step(3'b110, 0, 0);   chk("R8 zero", oc_ref, 1'b0);
    step(3'b110, 65534, 65535); chk("R8 top", oc_ref, 1'b1);
    step(3'b111, 3, 5);   chk("R9 below", oc_ref, 1'b0);
    step(3'b111, 5, 5);   chk("R9 equal", oc_ref, 1'b1);
    step(3'b111, 9, 5);   chk("R9 above", oc_ref, 1'b1);
  endtask

  task automatic t_polarity;
    out_en = 1'b1;
    pol_inv = 1'b0;
    step(3'b101, 0, 0);   chk("R10 pol0 act", oc_pin, 1'b1);
    pol_inv = 1'b1;
    step(3'b101, 0, 0);   chk("R10 pol1 act", oc_pin, 1'b0);
    step(3'b100, 0, 0);   chk("R10 pol1 inact", oc_pin, 1'b1);
    pol_inv = 1'b0;
    step(3'b100, 0, 0);   chk("R10 pol0 inact", oc_pin, 1'b0);
  endtask

  task automatic t_enable;
    out_en = 1'b0;
    pol_inv = 1'b0;
    step(3'b101, 0, 0);   chk("R11 pin", oc_pin, 1'b0);
                          chk("R11 ref tracks", oc_ref, 1'b1);
    pol_inv = 1'b1;
    step(3'b100, 0, 0);   chk("R11 pin inv", oc_pin, 1'b0);
    out_en = 1'b1;
    pol_inv = 1'b0;
  endtask

  task automatic t_direction;
    step(3'b101, 0, 0);
    dir_sel = 2'b01;
    step(3'b100, 0, 0);   chk("R12 ref held 01", oc_ref, 1'b1);
                          chk("R12 pin 01", oc_pin, 1'b0);
    dir_sel = 2'b10;
    step(3'b110, 9, 1);   chk("R12 ref held 10", oc_ref, 1'b1);
    dir_sel = 2'b11;
    step(3'b011, 4, 4);   chk("R12 ref held 11", oc_ref, 1'b1);
    dir_sel = 2'b00;
    step(3'b100, 0, 0);   chk("R12 back to output", oc_ref, 1'b0);
  endtask

  initial begin
    t_reset();
    t_force();
    t_frozen();
    t_set_clear();
    t_toggle();
    t_pwm();
    t_polarity();
    t_enable();
    t_direction();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule